// File: doc/BRIEF.md
# Ring Neighbour Diagnosis Controller

This controller sits in one node of a ring of identical nodes. Each node has links to its next and next-but-one neighbours on both sides. The controller checks its predecessor on a fixed schedule. It raises a test request, and it treats a missing reply within a window of clock cycles as a failed test. When a test fails, it asks the node two places back to test the same predecessor. It then combines the two verdicts. If both testers saw a failure, the predecessor itself is faulty. If the verdicts disagree, only a link is bad.

A faulty predecessor starts recovery, and this node leads it. Each recovery step is first mirrored to the partner tester through a request/acknowledge pair. Only after that acknowledge does the step itself go out on its own request/acknowledge pair. Four steps run in a fixed order. The work inside each step belongs to other logic. A per-step timeout stops the sequence and raises an error. A sticky four-bit path status marks defective neighbours. When both predecessors are marked, a flag reports that this stretch of the ring is no longer watched.

Top module: `ring_diag_ctrl`

## Requirements
- R1: After reset, and again after each passing reply, `probe_req` rises exactly PERIOD clock cycles later. It stays high until a reply arrives or the window expires.
- R2: If no `probe_ack` arrives, `probe_req` stays high for exactly WINDOW cycles. This counts as a failed test.
- R3: A failed test (a reply with `probe_pass`=0, or a timeout) drops `probe_req` and raises `peer_req` on the same edge. `probe_req` and `peer_req` are never high together.
- R4: If the partner also reports failure (`peer_pass`=0 with `peer_ack`, or no reply within WINDOW cycles), the node is faulty. `node_fault` sets, `path_status[0]` sets and `link_fault` stays 0. Testing stops and recovery starts.
- R5: If the partner reports a pass, only a link has failed. `link_fault` and `path_status[0]` set, `node_fault` stays 0, no recovery starts, and testing resumes.
- R6: The path status bits are: bit 0 = predecessor, bit 1 = node two back, bit 2 = successor, bit 3 = node two ahead. A pulse on `mark_set[k]` sets bit k one cycle later. Bits only clear at reset.
- R7: `seg_unmonitored` is high one cycle after bits 0 and 1 of the path status are both set, and low otherwise.
- R8: Every recovery step is first raised on `mirror_req` with its code on `step_id`. `step_req` rises only on the edge after `mirror_ack`. `step_id` is stable while `step_req` is high.
- R9: The steps run in this order: code 0 tells the far neighbours, code 1 cancels delegated tasks, code 2 hands out resources, code 3 re-delegates queued tasks. A step advances only on `step_done`. `recov_done` sets after `step_done` of code 3.
- R10: If a mirror or step acknowledge does not arrive within STEP_TO cycles, `step_err` sets and both requests drop. The sequence then stops until reset.
- R11: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mark_set | input | 4 | Pulses that mark neighbour links defective |
| probe_ack | input | 1 | Reply from the predecessor |
| probe_pass | input | 1 | Reply verdict, 1 = healthy |
| probe_req | output | 1 | Test request to the predecessor |
| peer_ack | input | 1 | Verdict valid from the node two back |
| peer_pass | input | 1 | Partner verdict, 1 = predecessor healthy |
| peer_req | output | 1 | Request for the node two back to test |
| path_status | output | 4 | Sticky defective-neighbour bits |
| link_fault | output | 1 | A link failure was concluded |
| node_fault | output | 1 | The predecessor was declared faulty |
| seg_unmonitored | output | 1 | Both predecessors marked defective |
| mirror_ack | input | 1 | Partner accepted the forwarded step |
| mirror_req | output | 1 | Forward the current step to the partner |
| step_done | input | 1 | Current recovery step finished |
| step_req | output | 1 | Run the current recovery step |
| step_id | output | 2 | Code of the current step |
| recov_done | output | 1 | All four steps finished |
| step_err | output | 1 | A step handshake timed out |

## Verification
Assertions check the properties that hold on every cycle:
- the two test requests are never high together;
- a timeout hands over to the partner;
- the fault outcomes exclude each other;
- the path bits are sticky and the unmonitored flag follows them;
- each step is mirrored before it runs, its code is held, and the error state stays silent.

The bench scenarios cover what needs a count or a whole sequence:
- the exact test period and reply window;
- each combination of pass, fail and silence from the two testers, with its outcome;
- the order of the four step codes and that a step waits for its done;
- the step timeout.

// File: rtl/ring_diag_pkg.sv
package ring_diag_pkg;

  // path status bit positions
  localparam int LNK_PRED  = 0;
  localparam int LNK_PRED2 = 1;

  typedef enum logic [1:0] {
    PB_WAIT,
    PB_TEST,
    PB_PEER,
    PB_HOLD
  } probe_st_t;

  typedef enum logic [1:0] {
    RC_IDLE,
    RC_FWD,
    RC_EXEC,
    RC_STOP
  } rec_st_t;

  typedef enum logic [1:0] {
    STEP_NOTIFY     = 2'd0,
    STEP_CANCEL     = 2'd1,
    STEP_SHARE      = 2'd2,
    STEP_REDELEGATE = 2'd3
  } step_t;

endpackage

// File: rtl/ring_probe.sv
module ring_probe
  import ring_diag_pkg::*;
#(
  parameter int PERIOD = 16,
  parameter int WINDOW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic probe_ack,
  input  logic probe_pass,
  input  logic peer_ack,
  input  logic peer_pass,
  output logic probe_req,
  output logic peer_req,
  output logic link_fault,
  output logic node_fault,
  output logic node_hit,
  output logic link_hit
);
  localparam int SPAN = (PERIOD > WINDOW) ? PERIOD : WINDOW;
  localparam int CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] PER_LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW - 1);

  probe_st_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PB_WAIT;
      cnt        <= '0;
      probe_req  <= 1'b0;
      peer_req   <= 1'b0;
      link_fault <= 1'b0;
      node_fault <= 1'b0;
      node_hit   <= 1'b0;
      link_hit   <= 1'b0;
    end else begin
      node_hit <= 1'b0;
      link_hit <= 1'b0;
      case (st)
        PB_WAIT: begin
          if (cnt == PER_LAST) begin
            cnt       <= '0;
            probe_req <= 1'b1;
            st        <= PB_TEST;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PB_TEST: begin
          if (probe_ack) begin
            probe_req <= 1'b0;
            cnt       <= '0;
            if (probe_pass) begin
              st <= PB_WAIT;
            end else begin
              peer_req <= 1'b1;
              st       <= PB_PEER;
            end
          end else if (cnt == WIN_LAST) begin
            probe_req <= 1'b0;
            peer_req  <= 1'b1;
            cnt       <= '0;
            st        <= PB_PEER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PB_PEER: begin
          if (peer_ack || cnt == WIN_LAST) begin
            peer_req <= 1'b0;
            cnt      <= '0;
            if (peer_ack && peer_pass) begin
              link_fault <= 1'b1;
              link_hit   <= 1'b1;
              st         <= PB_WAIT;
            end else begin
              node_fault <= 1'b1;
              node_hit   <= 1'b1;
              st         <= PB_HOLD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= PB_HOLD;
      endcase
    end
  end

  // R3: the two testers are never asked at once
  a_r3_one_tester: assert property (@(posedge clk) disable iff (rst)
    !(probe_req && peer_req));

  // R3: a request dropped without a reply hands over to the partner
  a_r3_timeout_handover: assert property (@(posedge clk) disable iff (rst)
    ($fell(probe_req) && !$past(probe_ack)) |-> peer_req);

  // R4: a faulty predecessor stops further testing
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    node_fault |=> (node_fault && !probe_req && !peer_req));

  // R5: a link verdict never coexists with a node verdict
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(node_hit && link_hit));

endmodule

// File: rtl/ring_paths.sv
module ring_paths
  import ring_diag_pkg::*;
#(
  parameter int NLINK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pred_hit,
  input  logic [NLINK-1:0] mark_set,
  output logic [NLINK-1:0] path_status,
  output logic             seg_unmonitored
);
  for (genvar k = 0; k < NLINK; k++) begin : g_bit
    logic set_k;
    if (k == LNK_PRED) begin : g_pred
      assign set_k = mark_set[k] | pred_hit;
    end else begin : g_other
      assign set_k = mark_set[k];
    end
    always_ff @(posedge clk) begin
      if (rst)        path_status[k] <= 1'b0;
      else if (set_k) path_status[k] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seg_unmonitored <= 1'b0;
    else     seg_unmonitored <= path_status[LNK_PRED] & path_status[LNK_PRED2];
  end

  // R6: marks only accumulate
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    ((path_status & $past(path_status)) == $past(path_status)));

  // R7: flag follows both predecessor marks a cycle later
  a_r7_flag: assert property (@(posedge clk) disable iff (rst)
    (path_status[LNK_PRED] && path_status[LNK_PRED2]) |=> seg_unmonitored);

endmodule

// File: rtl/ring_recover.sv
module ring_recover
  import ring_diag_pkg::*;
#(
  parameter int STEP_TO = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mirror_ack,
  input  logic       step_done,
  output logic       mirror_req,
  output logic       step_req,
  output logic [1:0] step_id,
  output logic       recov_done,
  output logic       step_err
);
  localparam int CW = $clog2(STEP_TO + 1);
  localparam logic [CW-1:0] TO_LAST = CW'(STEP_TO - 1);

  rec_st_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RC_IDLE;
      cnt        <= '0;
      mirror_req <= 1'b0;
      step_req   <= 1'b0;
      step_id    <= STEP_NOTIFY;
      recov_done <= 1'b0;
      step_err   <= 1'b0;
    end else begin
      case (st)
        RC_IDLE: begin
          if (start) begin
            mirror_req <= 1'b1;
            step_id    <= STEP_NOTIFY;
            cnt        <= '0;
            st         <= RC_FWD;
          end
        end
        RC_FWD: begin
          if (mirror_ack) begin
            mirror_req <= 1'b0;
            step_req   <= 1'b1;
            cnt        <= '0;
            st         <= RC_EXEC;
          end else if (cnt == TO_LAST) begin
            mirror_req <= 1'b0;
            step_err   <= 1'b1;
            st         <= RC_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RC_EXEC: begin
          if (step_done) begin
            step_req <= 1'b0;
            cnt      <= '0;
            if (step_id == STEP_REDELEGATE) begin
              recov_done <= 1'b1;
              st         <= RC_STOP;
            end else begin
              step_id    <= step_id + 2'd1;
              mirror_req <= 1'b1;
              st         <= RC_FWD;
            end
          end else if (cnt == TO_LAST) begin
            step_req <= 1'b0;
            step_err <= 1'b1;
            st       <= RC_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RC_STOP;
      endcase
    end
  end

  // R8: a step runs only after its forward was acknowledged
  a_r8_mirror_first: assert property (@(posedge clk) disable iff (rst)
    $rose(step_req) |-> $past(mirror_ack));

  // R8: step code held while the step runs
  a_r8_code_hold: assert property (@(posedge clk) disable iff (rst)
    (step_req && $past(step_req)) |-> $stable(step_id));

  // R9: completion only after the last step's done
  a_r9_done_last: assert property (@(posedge clk) disable iff (rst)
    $rose(recov_done) |-> ($past(step_done) && $past(step_id) == 2'd3));

  // R10: error state is final and silent
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (rst)
    step_err |=> (step_err && !step_req && !mirror_req && !recov_done));

endmodule

// File: rtl/ring_diag_ctrl.sv
module ring_diag_ctrl
  import ring_diag_pkg::*;
#(
  parameter int PERIOD  = 16,
  parameter int WINDOW  = 8,
  parameter int STEP_TO = 12,
  parameter int NLINK   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINK-1:0] mark_set,
  input  logic             probe_ack,
  input  logic             probe_pass,
  output logic             probe_req,
  input  logic             peer_ack,
  input  logic             peer_pass,
  output logic             peer_req,
  output logic [NLINK-1:0] path_status,
  output logic             link_fault,
  output logic             node_fault,
  output logic             seg_unmonitored,
  input  logic             mirror_ack,
  output logic             mirror_req,
  input  logic             step_done,
  output logic             step_req,
  output logic [1:0]       step_id,
  output logic             recov_done,
  output logic             step_err
);
  logic node_hit;
  logic link_hit;

  ring_probe #(.PERIOD(PERIOD), .WINDOW(WINDOW)) u_probe (
    .clk(clk), .rst(rst),
    .probe_ack(probe_ack), .probe_pass(probe_pass),
    .peer_ack(peer_ack), .peer_pass(peer_pass),
    .probe_req(probe_req), .peer_req(peer_req),
    .link_fault(link_fault), .node_fault(node_fault),
    .node_hit(node_hit), .link_hit(link_hit)
  );

  ring_paths #(.NLINK(NLINK)) u_paths (
    .clk(clk), .rst(rst),
    .pred_hit(node_hit | link_hit),
    .mark_set(mark_set),
    .path_status(path_status),
    .seg_unmonitored(seg_unmonitored)
  );

  ring_recover #(.STEP_TO(STEP_TO)) u_rec (
    .clk(clk), .rst(rst),
    .start(node_hit),
    .mirror_ack(mirror_ack), .step_done(step_done),
    .mirror_req(mirror_req), .step_req(step_req),
    .step_id(step_id), .recov_done(recov_done), .step_err(step_err)
  );

  // R5: a link verdict never launches recovery
  a_r5_no_recovery: assert property (@(posedge clk) disable iff (rst)
    (link_fault && !node_fault) |-> (!mirror_req && !step_req));

endmodule

// File: tb/sim_ring_diag_ctrl.sv
module sim_ring_diag_ctrl;
  localparam int CLK_NS  = 10;
  localparam int PERIOD  = 16;
  localparam int WINDOW  = 8;
  localparam int STEP_TO = 12;

  // {probe kind, peer kind, outcome}; kind 0 pass, 1 fail, 2 silent
  // outcome 0 healthy, 1 link, 2 node
  localparam logic [5:0] VEC [0:5] = '{
    {2'd0, 2'd0, 2'd0},
    {2'd1, 2'd0, 2'd1},
    {2'd2, 2'd0, 2'd1},
    {2'd1, 2'd1, 2'd2},
    {2'd1, 2'd2, 2'd2},
    {2'd2, 2'd1, 2'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] mark_set = '0;
  logic probe_ack = 0, probe_pass = 0, peer_ack = 0, peer_pass = 0;
  logic mirror_ack = 0, step_done = 0;
  logic probe_req, peer_req, link_fault, node_fault, seg_unmonitored;
  logic mirror_req, step_req, recov_done, step_err;
  logic [3:0] path_status;
  logic [1:0] step_id;

  int total = 0;
  int bad = 0;

  ring_diag_ctrl #(.PERIOD(PERIOD), .WINDOW(WINDOW), .STEP_TO(STEP_TO)) u0 (
    .clk(clk), .rst(rst), .mark_set(mark_set),
    .probe_ack(probe_ack), .probe_pass(probe_pass), .probe_req(probe_req),
    .peer_ack(peer_ack), .peer_pass(peer_pass), .peer_req(peer_req),
    .path_status(path_status), .link_fault(link_fault), .node_fault(node_fault),
    .seg_unmonitored(seg_unmonitored), .mirror_ack(mirror_ack),
    .mirror_req(mirror_req), .step_done(step_done), .step_req(step_req),
    .step_id(step_id), .recov_done(recov_done), .step_err(step_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    mark_set = '0; probe_ack = 0; probe_pass = 0; peer_ack = 0; peer_pass = 0;
    mirror_ack = 0; step_done = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic sig(int w);
    case (w)
      0: return probe_req;
      1: return peer_req;
      2: return mirror_req;
      default: return step_req;
    endcase
  endfunction

  task automatic wait_for(int which, int limit, output int waited);
    waited = -1;
    for (int n = 0; n <= limit; n++) begin
      if (sig(which)) begin
        waited = n;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic reply(bit to_peer, int kind);
    if (kind == 2) return;
    if (to_peer) begin peer_ack = 1; peer_pass = (kind == 0); end
    else begin probe_ack = 1; probe_pass = (kind == 0); end
    @(negedge clk);
    peer_ack = 0; peer_pass = 0; probe_ack = 0; probe_pass = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int w;
    int hi;
    // R11 reset state
    do_reset();
    check_eq("R11 outputs after reset",
             {probe_req, peer_req, path_status, link_fault, node_fault,
              seg_unmonitored, mirror_req, step_req, step_id, recov_done, step_err}, 0);

    // R1 first test after PERIOD cycles
    wait_for(0, PERIOD + 4, w);
    check_eq("R1 cycles to first probe", w, PERIOD);
    // R2 silent predecessor: request held for WINDOW cycles
    hi = 0;
    for (int n = 0; n < WINDOW + 4 && probe_req; n++) begin
      hi++;
      @(negedge clk);
    end
    check_eq("R2 probe window length", hi, WINDOW);
    check_eq("R3 peer asked on timeout", peer_req, 1);

    // table walk: outcomes R4 R5
    for (int v = 0; v < 6; v++) begin
      int pk, qk, oc;
      bit saw_probe, saw_mirror;
      pk = VEC[v][5:4]; qk = VEC[v][3:2]; oc = VEC[v][1:0];
      do_reset();
      wait_for(0, PERIOD + 4, w);
      check_eq("R1 probe seen", w, PERIOD);
      reply(1'b0, pk);
      if (pk != 0) begin
        wait_for(1, WINDOW + 4, w);
        check_eq("R3 peer request raised", (w >= 0) ? 1 : 0, 1);
        check_eq("R3 no probe with peer", probe_req, 0);
        reply(1'b1, qk);
      end
      saw_probe = 0; saw_mirror = 0;
      for (int n = 0; n < PERIOD + 12; n++) begin
        @(negedge clk);
        saw_probe  |= probe_req;
        saw_mirror |= mirror_req;
      end
      if (oc == 2) begin
        check_eq("R4 node_fault", node_fault, 1);
        check_eq("R4 link_fault clear", link_fault, 0);
        check_eq("R4 path bit0", path_status, 4'b0001);
        check_eq("R4 testing stopped", saw_probe, 0);
        check_eq("R4 recovery started", saw_mirror, 1);
      end else if (oc == 1) begin
        check_eq("R5 link_fault", link_fault, 1);
        check_eq("R5 node_fault clear", node_fault, 0);
        check_eq("R5 path bit0", path_status, 4'b0001);
        check_eq("R5 testing resumed", saw_probe, 1);
        check_eq("R5 no recovery", saw_mirror, 0);
      end else begin
        check_eq("R1 healthy path clear", path_status, 0);
        check_eq("R1 healthy probing again", saw_probe, 1);
        check_eq("R1 healthy no faults", {link_fault, node_fault}, 0);
      end
    end

    // R6 R7 marks and unmonitored flag
    do_reset();
    mark_set = 4'b0100;
    @(negedge clk);
    mark_set = 4'b0000;
    check_eq("R6 mark successor", path_status, 4'b0100);
    check_eq("R7 flag low with one mark", seg_unmonitored, 0);
    mark_set = 4'b0011;
    @(negedge clk);
    mark_set = 4'b0000;
    check_eq("R6 marks accumulate", path_status, 4'b0111);
    @(negedge clk);
    check_eq("R7 flag after both predecessors", seg_unmonitored, 1);
    repeat (3) @(negedge clk);
    check_eq("R6 marks sticky", path_status, 4'b0111);

    // R8 R9 full recovery
    do_reset();
    wait_for(0, PERIOD + 4, w);
    reply(1'b0, 1);
    wait_for(1, WINDOW + 4, w);
    reply(1'b1, 1);
    for (int k = 0; k < 4; k++) begin
      wait_for(2, STEP_TO, w);
      check_eq("R8 mirror raised", (w >= 0) ? 1 : 0, 1);
      check_eq("R9 step code order", step_id, k);
      check_eq("R8 step waits for mirror", step_req, 0);
      mirror_ack = 1;
      @(negedge clk);
      mirror_ack = 0;
      check_eq("R8 step after mirror ack", step_req, 1);
      check_eq("R8 mirror dropped", mirror_req, 0);
      repeat (3) @(negedge clk);
      check_eq("R9 step held until done", {step_req, step_id}, {1'b1, 2'(k)});
      step_done = 1;
      @(negedge clk);
      step_done = 0;
    end
    check_eq("R9 recovery done", recov_done, 1);
    check_eq("R10 no error", step_err, 0);

    // R10 step timeout
    do_reset();
    wait_for(0, PERIOD + 4, w);
    reply(1'b0, 2);
    wait_for(1, WINDOW + 4, w);
    reply(1'b1, 2);
    wait_for(2, 6, w);
    mirror_ack = 1;
    @(negedge clk);
    mirror_ack = 0;
    repeat (STEP_TO + 2) @(negedge clk);
    check_eq("R10 step_err on timeout", step_err, 1);
    check_eq("R10 requests dropped", {step_req, mirror_req, recov_done}, 0);

    finish_run();
  end
endmodule